// File: doc/BRIEF.md
# Indexed Store High-Byte Corruption Unit

This unit sequences the bus cycles of a group of unofficial store instructions in an 8-bit CPU. Each of these stores uses an indexed address, and the value it writes is the masked source register ANDed with a hidden byte H. Normally H is the base high address byte plus one. When adding the index carries out of the low byte, the high byte of the address is replaced by that incremented byte ANDed with the source value. If the CPU is held by a low `rdy_i` during the dummy read, H saturates to all ones and the AND term drops out of the stored data.

The host CPU pulses `start_i` with an operation code when it has decoded one of these opcodes. The unit then drives its own operand fetches, dummy read and write on the address bus, and returns the bus to the program counter when it finishes. The source registers are sampled at start. One form loads the stack pointer as a side effect.

Top module: `hbs_store_unit`

## Requirements
- R1: While `rst_ni` is low, `addr_o`, `we_o` and `wdata_o` are zero and `sp_o` equals the parameter SP_RST (default 0xFD). When idle, `addr_o` follows `pc_i` one cycle later.
- R2: The operation codes on `op_i` are: 0 = SHA abs,Y; 1 = SHA (zp),Y; 2 = SHX abs,Y; 3 = SHY abs,X; 4 = SHS abs,Y. An absolute form makes four bus cycles in this order: read pc, read pc+1, a dummy read at {base_hi, low byte of base+index}, and one write. `we_o` is high for exactly one cycle.
- R3: With `rdy_i` high in the dummy read, the write data is SHA: A&X&H, SHX: X&H, SHY: Y&H, SHS: (A&X)&H, where H = base_hi+1 (mod 256).
- R4: When base_lo+index carries, the write address high byte is (base_hi+1) & V, where V is A&X for SHA and SHS, X for SHX and Y for SHY. Without a carry, the high byte is base_hi.
- R5: If `rdy_i` is low in any cycle of the dummy read, H becomes 0xFF and the written data is the plain source value V. The page-cross corruption of R4 still applies.
- R6: A read cycle with `rdy_i` low repeats with the same address and does not advance. The write cycle completes even when `rdy_i` is low.
- R7: SHS loads `sp_o` with A&X in the same cycle as its write. No other operation changes `sp_o`.
- R8: In the cycle after the write, `we_o` is low and `addr_o` equals `pc_i`.
- R9: A start with `op_i` in the range 5 to 7 is ignored: no bus cycle is run and no write is made.
- R10: The (zp),Y form reads pc to get zp, then reads the pointer low byte at {0x00, zp} and the pointer high byte at {0x00, (zp+1) mod 256}, then runs the dummy read and the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| op_i | input | 3 | Operation code (see R2) |
| pc_i | input | 16 | Program counter of the host CPU |
| a_i | input | 8 | Accumulator |
| x_i | input | 8 | X index register |
| y_i | input | 8 | Y index register |
| rdy_i | input | 1 | Ready; low stalls read cycles |
| rd_data_i | input | 8 | Read data for the current bus cycle |
| addr_o | output | 16 | Registered bus address |
| we_o | output | 1 | Write strobe (1 = write, 0 = read) |
| wdata_o | output | 8 | Registered write data |
| sp_o | output | 8 | Stack pointer |

## Verification
The assertions assume three things about the inputs. `start_i` is raised only while the unit is idle. `rd_data_i` is valid in every read cycle. `pc_i` is stable during an operation and at the cycle that follows its write. The bench respects these assumptions. It drives inputs only on the falling edge and pulses `start_i` only after the previous write has returned the bus to the program counter. It computes `rd_data_i` from `addr_o` with a small memory model, and it pulls `rdy_i` low only at chosen steps (an operand fetch, the dummy read or the write), so that each stall effect is checked on its own.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [2:0] {
    OP_SHA_AY = 3'd0,
    OP_SHA_IY = 3'd1,
    OP_SHX_AY = 3'd2,
    OP_SHY_AX = 3'd3,
    OP_SHS_AY = 3'd4
  } hbs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OPLO  = 3'd1,
    ST_OPHI  = 3'd2,
    ST_PTRLO = 3'd3,
    ST_PTRHI = 3'd4,
    ST_DUMMY = 3'd5,
    ST_WRITE = 3'd6
  } hbs_st_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/hbs_idx_add.sv
module hbs_idx_add #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] idx_i,
  output logic [DW-1:0] sum_o,
  output logic          carry_o
);
  logic [DW:0] full;
  assign full    = {1'b0, base_i} + {1'b0, idx_i};
  assign sum_o   = full[DW-1:0];
  assign carry_o = full[DW];
endmodule

// File: rtl/hbs_hterm.sv
module hbs_hterm #(
  parameter int DW = 8
) (
  input  hbs_pkg::hbs_op_e op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    y_i,
  input  logic [DW-1:0]    hi_i,
  input  logic             carry_i,
  input  logic [DW-1:0]    h_i,
  input  logic             rdy_i,
  output logic [DW-1:0]    h_nxt_o,
  output logic [DW-1:0]    hi_eff_o,
  output logic [DW-1:0]    wdata_o
);
  import hbs_pkg::*;

  logic [DW-1:0] src;
  logic [DW-1:0] hi_inc;

  always_comb begin
    unique case (op_i)
      OP_SHX_AY: src = x_i;
      OP_SHY_AX: src = y_i;
      default:   src = a_i & x_i;
    endcase
  end

  assign hi_inc   = hi_i + {{(DW-1){1'b0}}, 1'b1};
  // a stalled dummy read saturates H so the mask drops out
  assign h_nxt_o  = rdy_i ? (h_i | hi_inc) : {DW{1'b1}};
  assign hi_eff_o = carry_i ? (hi_inc & src) : hi_i;
  assign wdata_o  = src & h_nxt_o;
endmodule

// File: rtl/hbs_store_unit.sv
module hbs_store_unit #(
  parameter int          DW     = 8,
  parameter logic [7:0]  SP_RST = 8'hFD,
  localparam int         AW     = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] sp_o
);
  import hbs_pkg::*;

  hbs_st_e       st_q;
  hbs_op_e       op_q;
  logic [DW-1:0] a_q, x_q, y_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] lo_q, hi_q, h_q;
  logic          carry_q;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [DW-1:0] wdata_q, sp_q;

  logic [DW-1:0] idx, sum_lo, h_nxt, hi_eff, wdata_c;
  logic          carry_c;

  assign idx = (op_q == OP_SHY_AX) ? x_q : y_q;

  hbs_idx_add #(.DW(DW)) u_add (
    .base_i  (lo_q),
    .idx_i   (idx),
    .sum_o   (sum_lo),
    .carry_o (carry_c)
  );

  hbs_hterm #(.DW(DW)) u_hterm (
    .op_i     (op_q),
    .a_i      (a_q),
    .x_i      (x_q),
    .y_i      (y_q),
    .hi_i     (hi_q),
    .carry_i  (carry_q),
    .h_i      (h_q),
    .rdy_i    (rdy_i),
    .h_nxt_o  (h_nxt),
    .hi_eff_o (hi_eff),
    .wdata_o  (wdata_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_SHA_AY;
      a_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      pc_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      h_q     <= '0;
      carry_q <= 1'b0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      sp_q    <= SP_RST[DW-1:0];
    end else begin
      we_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          addr_q <= pc_i;
          if (start_i && op_known(op_i)) begin
            op_q <= hbs_op_e'(op_i);
            a_q  <= a_i;
            x_q  <= x_i;
            y_q  <= y_i;
            pc_q <= pc_i;
            st_q <= ST_OPLO;
          end
        end
        ST_OPLO: if (rdy_i) begin
          lo_q <= rd_data_i;
          if (op_q == OP_SHA_IY) begin
            addr_q <= {{DW{1'b0}}, rd_data_i};
            st_q   <= ST_PTRLO;
          end else begin
            addr_q <= pc_q + {{(AW-1){1'b0}}, 1'b1};
            st_q   <= ST_OPHI;
          end
        end
        ST_PTRLO: if (rdy_i) begin
          // pointer high byte wraps inside page zero
          addr_q <= {{DW{1'b0}}, lo_q + {{(DW-1){1'b0}}, 1'b1}};
          lo_q   <= rd_data_i;
          st_q   <= ST_PTRHI;
        end
        ST_OPHI, ST_PTRHI: if (rdy_i) begin
          hi_q    <= rd_data_i;
          lo_q    <= sum_lo;
          carry_q <= carry_c;
          h_q     <= '0;
          addr_q  <= {rd_data_i, sum_lo};
          st_q    <= ST_DUMMY;
        end
        ST_DUMMY: begin
          h_q <= h_nxt;
          if (rdy_i) begin
            addr_q  <= {hi_eff, lo_q};
            we_q    <= 1'b1;
            wdata_q <= wdata_c;
            if (op_q == OP_SHS_AY) sp_q <= a_q & x_q;
            st_q    <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          addr_q <= pc_i;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign we_o    = we_q;
  assign wdata_o = wdata_q;
  assign sp_o    = sp_q;
endmodule

// File: rtl/hbs_store_unit_chk.sv
module hbs_store_unit_chk #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rdy_i,
  input logic [AW-1:0] pc_i,
  input logic [AW-1:0] addr_o,
  input logic          we_o,
  input logic [DW-1:0] sp_o,
  input logic [2:0]    st_i,
  input logic [DW-1:0] h_i
);
  import hbs_pkg::*;

  logic in_read;
  assign in_read = (st_i == ST_OPLO) || (st_i == ST_OPHI) || (st_i == ST_PTRLO) ||
                   (st_i == ST_PTRHI) || (st_i == ST_DUMMY);

  p_idle_reads_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !we_o);

  p_single_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);

  p_h_saturate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_DUMMY && !rdy_i) |=> (h_i == {DW{1'b1}}));

  p_read_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_read && !rdy_i) |=> ($stable(addr_o) && !we_o));

  p_write_unheld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (st_i == ST_IDLE));

  p_sp_on_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_o) |-> we_o);

  p_bus_to_pc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (addr_o == $past(pc_i)));
endmodule

bind hbs_store_unit hbs_store_unit_chk #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rdy_i  (rdy_i),
  .pc_i   (pc_i),
  .addr_o (addr_o),
  .we_o   (we_o),
  .sp_o   (sp_o),
  .st_i   (st_q),
  .h_i    (h_q)
);

// File: tb/hbs_store_unit_bench.sv
module hbs_store_unit_bench;
  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  a, x, y, blo, bhi;
    logic        stall;
    logic [15:0] eaddr;
    logic [7:0]  edata;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'hFF, 8'hF0, 8'h10, 8'h20, 8'h12, 1'b0, 16'h1230, 8'h10},
    '{3'd0, 8'hFF, 8'hF0, 8'hF0, 8'h20, 8'h12, 1'b0, 16'h1010, 8'h10},
    '{3'd2, 8'h00, 8'hF6, 8'h05, 8'hFE, 8'h7E, 1'b0, 16'h7603, 8'h76},
    '{3'd2, 8'h00, 8'hF6, 8'h01, 8'h10, 8'h7E, 1'b0, 16'h7E11, 8'h76},
    '{3'd3, 8'h00, 8'h80, 8'hAA, 8'h90, 8'h05, 1'b0, 16'h0210, 8'h02},
    '{3'd3, 8'h00, 8'h01, 8'hAA, 8'h90, 8'h05, 1'b0, 16'h0591, 8'h02},
    '{3'd4, 8'hF3, 8'h3F, 8'h02, 8'h00, 8'h20, 1'b0, 16'h2002, 8'h21},
    '{3'd4, 8'hF3, 8'h3F, 8'h02, 8'hFF, 8'h20, 1'b0, 16'h2101, 8'h21},
    '{3'd1, 8'hFF, 8'h0F, 8'h80, 8'h90, 8'h34, 1'b0, 16'h0510, 8'h05},
    '{3'd1, 8'hFF, 8'h0F, 8'h01, 8'h90, 8'h34, 1'b0, 16'h3491, 8'h05},
    '{3'd2, 8'h00, 8'hF6, 8'h05, 8'hFE, 8'h7E, 1'b1, 16'h7603, 8'hF6},
    '{3'd0, 8'hFF, 8'hF0, 8'h10, 8'h20, 8'h12, 1'b1, 16'h1230, 8'hF0},
    '{3'd3, 8'h00, 8'h80, 8'hAA, 8'h90, 8'h05, 1'b1, 16'h0210, 8'hAA},
    '{3'd4, 8'hF3, 8'h3F, 8'h02, 8'h00, 8'h20, 1'b1, 16'h2002, 8'h33},
    '{3'd1, 8'hFF, 8'h0F, 8'h80, 8'h90, 8'h34, 1'b1, 16'h0510, 8'h0F}
  };

  localparam logic [15:0] PC0 = 16'h0300;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] pc_i = PC0;
  logic [7:0]  a_i = '0, x_i = '0, y_i = '0;
  logic        rdy_i = 1'b1;
  logic [7:0]  rd_data_i;
  logic [15:0] addr_o;
  logic        we_o;
  logic [7:0]  wdata_o, sp_o;

  logic        ind_mode = 1'b0;
  logic [7:0]  m_lo = '0, m_hi = '0;
  int          n_chk = 0, n_err = 0;
  logic        done = 1'b0;

  always #5 clk_i = ~clk_i;

  hbs_store_unit u_hbs_store_unit (
    .clk_i, .rst_ni, .start_i, .op_i, .pc_i, .a_i, .x_i, .y_i,
    .rdy_i, .rd_data_i, .addr_o, .we_o, .wdata_o, .sp_o
  );

  always_comb begin
    rd_data_i = 8'hEE;
    if (ind_mode) begin
      if (addr_o == pc_i)          rd_data_i = 8'hFF;
      else if (addr_o == 16'h00FF) rd_data_i = m_lo;
      else if (addr_o == 16'h0000) rd_data_i = m_hi;
    end else begin
      if (addr_o == pc_i)              rd_data_i = m_lo;
      else if (addr_o == pc_i + 16'd1) rd_data_i = m_hi;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // run one operation; stall_at: 0 none, else cycle index with rdy low
  task automatic run_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] x,
                        input logic [7:0] y, input int stall_at, input int wr_stall,
                        output int nwr, output logic [15:0] waddr, output logic [7:0] wdat);
    nwr = 0; waddr = '0; wdat = '0;
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; x_i = x; y_i = y;
    ind_mode = (op == 3'd1);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      rdy_i = 1'b1;
      if (k == stall_at) rdy_i = 1'b0;
      if (we_o) begin
        nwr++; waddr = addr_o; wdat = wdata_o;
        if (wr_stall != 0) rdy_i = 1'b0;
      end
      @(negedge clk_i);
    end
    rdy_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int nwr;
    logic [15:0] wa;
    logic [7:0]  wd;
    logic [7:0]  exp_sp;
    exp_sp = 8'hFD;

    #12;
    chk(addr_o == 16'h0 && we_o == 1'b0 && wdata_o == 8'h0, "R1", "reset bus",
        {addr_o, wdata_o, 7'd0, we_o}, 32'h0);
    chk(sp_o == 8'hFD, "R1", "reset sp", sp_o, 8'hFD);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); pc_i = 16'h0456;
    @(negedge clk_i);
    chk(addr_o == 16'h0456, "R1", "idle follows pc", addr_o, 16'h0456);
    pc_i = PC0;
    @(negedge clk_i);

    // vector table: R2 R3 R4 R5 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      m_lo = VECS[i].blo; m_hi = VECS[i].bhi;
      run_op(VECS[i].op, VECS[i].a, VECS[i].x, VECS[i].y,
             VECS[i].stall ? ((VECS[i].op == 3'd1) ? 4 : 3) : 0, 0, nwr, wa, wd);
      chk(nwr == 1, "R2", $sformatf("vec %0d write count", i), nwr, 1);
      chk(wa == VECS[i].eaddr, VECS[i].op == 3'd1 ? "R10" : "R4",
          $sformatf("vec %0d address", i), wa, VECS[i].eaddr);
      chk(wd == VECS[i].edata, VECS[i].stall ? "R5" : "R3",
          $sformatf("vec %0d data", i), wd, VECS[i].edata);
      if (VECS[i].op == 3'd4) exp_sp = VECS[i].a & VECS[i].x;
      chk(sp_o == exp_sp, "R7", $sformatf("vec %0d sp", i), sp_o, exp_sp);
      chk(addr_o == PC0 && !we_o, "R8", $sformatf("vec %0d bus back to pc", i),
          addr_o, PC0);
    end

    // R9: unused codes ignored
    for (int c = 5; c <= 7; c++) begin
      m_lo = 8'h20; m_hi = 8'h12;
      run_op(3'(c), 8'hFF, 8'hFF, 8'h01, 0, 0, nwr, wa, wd);
      chk(nwr == 0, "R9", $sformatf("code %0d writes", c), nwr, 0);
      chk(addr_o == PC0, "R9", $sformatf("code %0d bus", c), addr_o, PC0);
      chk(sp_o == exp_sp, "R9", $sformatf("code %0d sp", c), sp_o, exp_sp);
    end

    // R6: stall in an operand fetch holds the address
    m_lo = 8'h10; m_hi = 8'h7E;
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'd2; a_i = 8'h00; x_i = 8'hF6; y_i = 8'h01; ind_mode = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0; rdy_i = 1'b0;
    @(negedge clk_i);
    chk(addr_o == PC0 && !we_o, "R6", "fetch held cycle 1", addr_o, PC0);
    @(negedge clk_i);
    chk(addr_o == PC0 && !we_o, "R6", "fetch held cycle 2", addr_o, PC0);
    rdy_i = 1'b1;
    @(negedge clk_i);
    chk(addr_o == PC0 + 16'd1, "R6", "fetch resumes", addr_o, PC0 + 16'd1);
    @(negedge clk_i);
    chk(addr_o == 16'h7E11 && !we_o, "R2", "dummy read address", addr_o, 16'h7E11);
    @(negedge clk_i);
    chk(we_o && addr_o == 16'h7E11 && wdata_o == 8'h76, "R6", "write after fetch stall",
        {addr_o, wdata_o}, {16'h7E11, 8'h76});
    @(negedge clk_i);

    // R6: rdy low during the write cycle does not hold it
    m_lo = 8'h90; m_hi = 8'h05;
    run_op(3'd3, 8'h00, 8'h01, 8'hAA, 0, 1, nwr, wa, wd);
    chk(nwr == 1 && wa == 16'h0591 && wd == 8'h02, "R6", "write not held",
        {wa, wd}, {16'h0591, 8'h02});
    chk(addr_o == PC0, "R8", "bus back after held-rdy write", addr_o, PC0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule